// File: doc/BRIEF.md
# I/O Control Command Executor

This block carries out one two-word I/O control command on behalf of an execute-I/O instruction. It is handed an effective address. It reads the command from memory at that address and the next one. The first word is a 16-bit address field. The second word is split, from the top bit down, into a 5-bit device code, a 3-bit function code and an 8-bit modifier. From these fields the block either moves one word between memory and the selected device, or passes a control or start action to the device, or loads a status word into the accumulator.

The command input, the memory port and the device bus all use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high. Once a requester raises valid, it holds valid and every field it drives steady until ready is seen. A responder may hold ready low for any number of cycles. Read data on the memory and device ports is taken on the handshake edge itself. A 32-bit presence vector, with one bit per device code, says which devices are attached. The block never places a request on the bus for a device that is absent.

The accumulator is written only through its write port and only by sense functions. The block has no path to the carry or overflow indicators. A done pulse marks the end of every command that is executed. An error pulse marks an odd effective address.

Top module: `iocc_exec`

## Requirements
- R1: An accepted command with an even effective address EA is fetched by exactly two memory reads, first at EA and then at EA+1. Word EA is the address field. In word EA+1, bits [15:11] are the device code, bits [10:8] the function code and bits [7:0] the modifier.
- R2: An odd effective address produces a one-cycle `err` pulse in the cycle after acceptance. No memory access, device access, accumulator write or `done` follows.
- R3: Function 001 (write), device present: one memory read at the address field, then one device handshake with `dev_func`=001 that carries the word just read on `dev_wdata`.
- R4: Function 010 (read), device present: one device handshake with `dev_func`=010, then one memory write of the returned `dev_rdata` at the address field. No other function ever writes memory.
- R5: Function 011 (sense interrupt) writes `ilsw` into the accumulator once and makes no device access, whatever the device code is.
- R6: Functions 100 (control), 101 (start write) and 110 (start read), device present: exactly one device handshake that carries the device code, function, modifier and address field, with no memory access after the fetch and no accumulator write.
- R7: Function 111 (sense device), device present: one device handshake that carries the modifier, whose bits request clearing of interrupt conditions. The returned `dev_rdata` is then written once into the accumulator.
- R8: Function 111 aimed at an absent device writes all zeros into the accumulator and makes no device access.
- R9: Functions 001, 010, 100, 101 and 110 aimed at an absent device complete with no device access and no memory access after the fetch.
- R10: Function 000 completes after the fetch with no further memory, device or accumulator activity.
- R11: `done` is a one-cycle pulse, sampled on the clock edge right after the edge of the command's last memory, device or accumulator transfer.
- R12: `cmd_ready` is high only while the block is idle. While `mem_valid` or `dev_valid` waits for ready, that valid and its address, data and direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Effective address offered |
| cmd_ready | output | 1 | Block idle, can accept a command |
| cmd_ea | input | 16 | Effective address of the command |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid on the handshake |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 16 | Accumulator write value |
| dev_present | input | 32 | One bit per device code, 1 = attached |
| ilsw | input | 16 | Status word of the interrupt level now serviced |
| dev_valid | output | 1 | Device bus request |
| dev_ready | input | 1 | Device accepts the request |
| dev_code | output | 5 | Selected device code |
| dev_func | output | 3 | Function code |
| dev_mod | output | 8 | Modifier |
| dev_addr | output | 16 | Address field |
| dev_wdata | output | 16 | Data to the device |
| dev_rdata | input | 16 | Data or status from the device, valid on the handshake |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Odd effective address pulse |

## Verification
On every cycle, the assertions check the handshake hold rules, the single-cycle width of `done`, and where an error pulse comes from. They also check that no device request goes to an absent device, that memory writes happen only for the read function, and that an accumulator write comes only from a sense function, with zeros for an absent device. The bench scenarios are what show the order and count of transfers for each function. They also show the fetch addresses, the data that moves between memory and the device, the accumulator values, and the exact cycle of `done`, both with and without back-pressure.

// File: rtl/iocc_pkg.sv
package iocc_pkg;

  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_NOP  = 3'b000,
    FN_WR   = 3'b001,
    FN_RD   = 3'b010,
    FN_SINT = 3'b011,
    FN_CTL  = 3'b100,
    FN_IWR  = 3'b101,
    FN_IRD  = 3'b110,
    FN_SDEV = 3'b111
  } fn_e;

  // What the sequencer must do after the fetch.
  typedef struct packed {
    logic mem_pre;   // read memory before the device step
    logic use_dev;   // one device handshake
    logic mem_post;  // write device data to memory afterwards
    logic acc_load;  // write the accumulator
    logic acc_ilsw;  // accumulator source is the level status word
  } plan_t;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_MRD, S_DEV, S_MWR, S_ACC, S_DONE, S_ERR
  } st_e;

endpackage

// File: rtl/iocc_decode.sv
module iocc_decode
  import iocc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEV_W = 5
) (
  input  logic [DW-1:0]          word,
  input  logic [(1<<DEV_W)-1:0]  present,
  output logic [DEV_W-1:0]       code,
  output fn_e                    fn,
  output logic [DW-DEV_W-FN_W-1:0] mod,
  output plan_t                  plan
);
  localparam int MOD_W = DW - DEV_W - FN_W;

  logic here;

  always_comb begin
    code = word[DW-1 -: DEV_W];
    fn   = fn_e'(word[MOD_W +: FN_W]);
    mod  = word[MOD_W-1:0];
    here = present[code];
    plan = '0;
    unique case (fn)
      FN_NOP:  plan = '0;
      FN_WR: begin
        plan.mem_pre = here;
        plan.use_dev = here;
      end
      FN_RD: begin
        plan.use_dev  = here;
        plan.mem_post = here;
      end
      FN_SINT: begin
        plan.acc_load = 1'b1;
        plan.acc_ilsw = 1'b1;
      end
      FN_CTL, FN_IWR, FN_IRD: plan.use_dev = here;
      FN_SDEV: begin
        plan.use_dev  = here;
        plan.acc_load = 1'b1;
      end
      default: plan = '0;
    endcase
  end

endmodule

// File: rtl/iocc_seq.sv
module iocc_seq
  import iocc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_ea,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_valid,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] dev_wdata,
  output logic [AW-1:0] dev_addr,
  output logic          acc_we,
  output logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] ilsw,
  input  plan_t         plan,
  output logic [DW-1:0] cmd_word,
  output logic          done,
  output logic          err
);
  st_e           st;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmd_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] acc_q;

  // During the second fetch the plan is decoded straight off the bus.
  assign cmd_word = (st == S_F1) ? mem_rdata : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ea_q   <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      data_q <= '0;
      acc_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          ea_q <= cmd_ea;
          st   <= cmd_ea[0] ? S_ERR : S_F0;
        end
        S_F0: if (mem_ready) begin
          addr_q <= mem_rdata[AW-1:0];
          st     <= S_F1;
        end
        S_F1: if (mem_ready) begin
          cmd_q <= mem_rdata;
          acc_q <= plan.acc_ilsw ? ilsw : '0;
          if (plan.mem_pre)       st <= S_MRD;
          else if (plan.use_dev)  st <= S_DEV;
          else if (plan.acc_load) st <= S_ACC;
          else                    st <= S_DONE;
        end
        S_MRD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= S_DEV;
        end
        S_DEV: if (dev_ready) begin
          if (plan.mem_post) begin
            data_q <= dev_rdata;
            st     <= S_MWR;
          end else if (plan.acc_load) begin
            acc_q <= dev_rdata;
            st    <= S_ACC;
          end else begin
            st <= S_DONE;
          end
        end
        S_MWR:  if (mem_ready) st <= S_DONE;
        S_ACC:  st <= S_DONE;
        S_DONE: st <= S_IDLE;
        S_ERR:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready = (st == S_IDLE);
    mem_valid = (st == S_F0) || (st == S_F1) || (st == S_MRD) || (st == S_MWR);
    mem_we    = (st == S_MWR);
    unique case (st)
      S_F0:         mem_addr = ea_q;
      S_F1:         mem_addr = {ea_q[AW-1:1], 1'b1};
      default:      mem_addr = addr_q;
    endcase
    mem_wdata = data_q;
    dev_valid = (st == S_DEV);
    dev_wdata = data_q;
    dev_addr  = addr_q;
    acc_we    = (st == S_ACC);
    acc_wdata = acc_q;
    done      = (st == S_DONE);
    err       = (st == S_ERR);
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_addr) && $stable(dev_wdata)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready && cmd_ea[0])); // R2
  AST_ODD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_ea[0] |=> !mem_valid && !dev_valid && !acc_we); // R2

endmodule

// File: rtl/iocc_exec.sv
module iocc_exec
  import iocc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEV_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [AW-1:0]             cmd_ea,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic [DW-1:0]             mem_rdata,
  output logic                      acc_we,
  output logic [DW-1:0]             acc_wdata,
  input  logic [(1<<DEV_W)-1:0]     dev_present,
  input  logic [DW-1:0]             ilsw,
  output logic                      dev_valid,
  input  logic                      dev_ready,
  output logic [DEV_W-1:0]          dev_code,
  output logic [FN_W-1:0]           dev_func,
  output logic [DW-DEV_W-FN_W-1:0]  dev_mod,
  output logic [AW-1:0]             dev_addr,
  output logic [DW-1:0]             dev_wdata,
  input  logic [DW-1:0]             dev_rdata,
  output logic                      done,
  output logic                      err
);
  localparam int MOD_W = DW - DEV_W - FN_W;

  logic [DW-1:0]    cmd_word;
  fn_e              fn;
  plan_t            plan;
  logic [MOD_W-1:0] mod;

  iocc_decode #(.DW(DW), .DEV_W(DEV_W)) u_dec (
    .word    (cmd_word),
    .present (dev_present),
    .code    (dev_code),
    .fn      (fn),
    .mod     (mod),
    .plan    (plan)
  );

  assign dev_func = fn;
  assign dev_mod  = mod;

  iocc_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_ea    (cmd_ea),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_rdata (dev_rdata),
    .dev_wdata (dev_wdata),
    .dev_addr  (dev_addr),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .ilsw      (ilsw),
    .plan      (plan),
    .cmd_word  (cmd_word),
    .done      (done),
    .err       (err)
  );

  AST_DEV_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> dev_present[dev_code]); // R9
  AST_MEMWR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> dev_func == FN_RD); // R4
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we && dev_func == FN_SDEV && !dev_present[dev_code] |-> acc_wdata == '0); // R8
  AST_ACC_SENSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (dev_func == FN_SINT) || (dev_func == FN_SDEV)); // R5

endmodule

// File: tb/tb_iocc_exec.sv
module tb_iocc_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_ea = '0;
  logic        mem_valid, mem_ready, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        acc_we;
  logic [15:0] acc_wdata;
  logic [31:0] dev_present = '0;
  logic [15:0] ilsw = 16'h4321;
  logic        dev_valid, dev_ready;
  logic [4:0]  dev_code;
  logic [2:0]  dev_func;
  logic [7:0]  dev_mod;
  logic [15:0] dev_addr, dev_wdata, dev_rdata;
  logic        done, err;

  iocc_exec dut (.*);

  logic [15:0] mem [256];
  logic        stall = 1'b0, tgl = 1'b0;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = !stall || tgl;
  assign dev_ready = !stall || !tgl;
  assign dev_rdata = {3'b101, dev_code, dev_mod};

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_mrd = 0, n_mwr = 0, n_dev = 0, n_acc = 0, n_done = 0, n_err = 0;
  int last_cyc = 0, done_cyc = 0, err_cyc = 0, acc_cyc = 0;
  logic [15:0] rd_log [1024];
  logic [15:0] ld_wdata, ld_addr, last_acc;
  logic [4:0]  ld_code;
  logic [2:0]  ld_func;
  logic [7:0]  ld_mod;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tgl <= ~tgl;
    if (rst_n) begin
      if (cmd_valid && cmd_ready) acc_cyc <= cyc;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          n_mwr <= n_mwr + 1;
        end else begin
          rd_log[n_mrd % 1024] <= mem_addr;
          n_mrd <= n_mrd + 1;
        end
        last_cyc <= cyc;
      end
      if (dev_valid && dev_ready) begin
        n_dev <= n_dev + 1;
        ld_code <= dev_code; ld_func <= dev_func; ld_mod <= dev_mod;
        ld_addr <= dev_addr; ld_wdata <= dev_wdata;
        last_cyc <= cyc;
      end
      if (acc_we) begin
        n_acc <= n_acc + 1;
        last_acc <= acc_wdata;
        last_cyc <= cyc;
      end
      if (done) begin n_done <= n_done + 1; done_cyc <= cyc; end
      if (err)  begin n_err <= n_err + 1;   err_cyc <= cyc;  end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] ea;
    logic [15:0] af;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [7:0]  mod;
    logic        pres;
    logic        stl;
    logic        edev;
    logic        emwr;
    logic        eacc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 16'h0080, 5'd2,  3'd1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h0012, 16'h0082, 5'd3,  3'd1, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0014, 16'h0084, 5'd9,  3'd2, 8'h33, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'h0016, 16'h0086, 5'd10, 3'd2, 8'h44, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'h0018, 16'h0088, 5'd0,  3'd3, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'h001A, 16'h008A, 5'd6,  3'd4, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h001C, 16'h008C, 5'd4,  3'd5, 8'h66, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h001E, 16'h008E, 5'd17, 3'd6, 8'h77, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0020, 16'h0090, 5'd17, 3'd7, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'h0022, 16'h0092, 5'd12, 3'd7, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'h0024, 16'h0094, 5'd5,  3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h0026, 16'h0096, 5'd7,  3'd2, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h0028, 16'h0098, 5'd1,  3'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h002A, 16'h009A, 5'd25, 3'd4, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic run_vec(input vec_t v);
    int b_mrd, b_mwr, b_dev, b_acc, b_done, b_err;
    int exp_rd;
    @(negedge clk);
    mem[v.ea[7:0]]        = v.af;
    mem[v.ea[7:0] + 8'd1] = {v.dev, v.fn, v.mod};
    mem[v.af[7:0]]        = v.af ^ 16'h5A5A;
    dev_present = v.pres ? (32'd1 << v.dev) : ~(32'd1 << v.dev);
    stall = v.stl;
    b_mrd = n_mrd; b_mwr = n_mwr; b_dev = n_dev; b_acc = n_acc; b_done = n_done; b_err = n_err;
    cmd_ea = v.ea; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 ready low while busy", cmd_ready, 0);
    for (int i = 0; i < 80 && n_done == b_done && n_err == b_err; i++) @(negedge clk);
    exp_rd = 2 + ((v.fn == 3'd1 && v.pres) ? 1 : 0);
    chk("R11 one done", n_done - b_done, 1);
    chk("R11 done timing", done_cyc, last_cyc + 1);
    chk("R1 read count", n_mrd - b_mrd, exp_rd);
    chk("R1 fetch first", rd_log[b_mrd % 1024], v.ea);
    chk("R1 fetch second", rd_log[(b_mrd + 1) % 1024], v.ea + 16'd1);
    chk("R4 R9 R10 mem writes", n_mwr - b_mwr, v.emwr);
    chk("R5 R8 R9 device accesses", n_dev - b_dev, v.edev);
    chk("R5 R7 R10 acc writes", n_acc - b_acc, v.eacc);
    if (v.edev) begin
      chk("R6 dev code", ld_code, v.dev);
      chk("R6 dev func", ld_func, v.fn);
      chk("R7 dev modifier", ld_mod, v.mod);
      chk("R6 dev address", ld_addr, v.af);
    end
    if (v.fn == 3'd1 && v.pres) chk("R3 write data", ld_wdata, v.af ^ 16'h5A5A);
    if (v.fn == 3'd2 && v.pres) chk("R4 memory gets device word", mem[v.af[7:0]], {3'b101, v.dev, v.mod});
    if (v.fn == 3'd3) chk("R5 ilsw loaded", last_acc, ilsw);
    if (v.fn == 3'd7 && v.pres) chk("R7 status loaded", last_acc, {3'b101, v.dev, v.mod});
    if (v.fn == 3'd7 && !v.pres) chk("R8 absent reads zero", last_acc, 0);
    stall = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    int b_mrd, b_dev, b_acc, b_done, b_err;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    repeat (3) @(negedge clk);
    chk("R12 reset ready", cmd_ready, 1);
    chk("R11 reset done", done, 0);
    chk("R2 reset err", err, 0);
    chk("R1 reset mem idle", mem_valid, 0);
    chk("R6 reset dev idle", dev_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R2: odd effective address
    @(negedge clk);
    b_mrd = n_mrd; b_dev = n_dev; b_acc = n_acc; b_done = n_done; b_err = n_err;
    cmd_ea = 16'h0031; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 one err pulse", n_err - b_err, 1);
    chk("R2 err timing", err_cyc, acc_cyc + 1);
    chk("R2 no done", n_done - b_done, 0);
    chk("R2 no memory", n_mrd - b_mrd, 0);
    chk("R2 no device", n_dev - b_dev, 0);
    chk("R2 no acc", n_acc - b_acc, 0);

    // back to back after error still works
    run_vec(VECS[2]);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule